// File: doc/BRIEF.md
# UART Interrupt Source Identification

This block gathers the interrupt conditions of one UART channel and reports them through a read-only identification byte and a single interrupt line. There are seven sources in a fixed priority order. The first is a receiver line error. Next come received data available and receive timeout, which share one level. Below them are transmit holding empty, modem line change, received flow-stop or special character, and flow-control pin change. Each source has an enable bit. A source whose enable bit is clear still records its event, but it is neither reported nor allowed to raise the line.

The identification byte shows only the most urgent enabled pending source. Software services that source, reads the byte again, and only then sees the next one down. Most sources are cleared by the logic that owns them, which sends a strobe into this block: a data read, a line status read or a modem status read. Two sources are cleared by this block itself, at the end of a status read that reported them: transmit holding empty and the flow-stop/special-character event. Transmit holding empty is also cleared by a write to the transmit holding register.

While a status read is in progress, the byte is frozen. Any event that arrives during the read is recorded and appears on the next read. The top two bits show whether the FIFOs are enabled.

Top module: `uart_irq_ident`

## Requirements
- R1: With nothing enabled and pending, status bits [5:0] read 000001 and `irq` is low; this is also the state during and right after reset.
- R2: `irq` is high exactly when at least one enabled source is pending, and status bit 0 is then 0.
- R3: A pending line error (enable bit 2) outranks every other source and reads 000110.
- R4: Data available (level input, enable bit 0) reads 000100 and receive timeout (latched, enable bit 0) reads 001100. Both rank below the line error, and data available wins when both are present.
- R5: Transmit holding empty (enable bit 1) reads 000010 and ranks above modem change (enable bit 3), which reads 000000.
- R6: Flow-stop/special character (enable bit 4) reads 010000 and flow-pin change (enable bit 5) reads 100000; the latter is the lowest priority of all.
- R7: Only the highest pending source is shown. A masked source is recorded but hidden, and it appears as soon as its enable bit is set.
- R8: Status bits [7:6] both equal `fifo_en`.
- R9: While `stat_rd` stays high, the status byte keeps the value seen in the first cycle of the read.
- R10: Transmit holding empty is set on a rising edge of (`tx_hold_empty` AND enable bit 1). It is cleared by `tx_hold_wr`, or when a read that reported 000010 ends.
- R11: The flow-stop/special-character event is cleared when a read that reported 010000 ends.
- R12: `line_stat_rd` clears the line error, `data_rd` clears the timeout, and `modem_stat_rd` clears both modem change and flow-pin change. An event that arrives in the same cycle as its clear strobe stays pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_en | input | 1 | FIFO enable state, mirrored in status bits [7:6] |
| ien | input | 6 | Source enables: 0 rx, 1 thr, 2 line, 3 modem, 4 flow-stop, 5 flow-pin |
| ev_line_err | input | 1 | Line error event pulse |
| rx_data_avail | input | 1 | Receive data available level |
| ev_rx_timeout | input | 1 | Receive timeout event pulse |
| tx_hold_empty | input | 1 | Transmit holding register empty level |
| ev_modem_delta | input | 1 | Modem line change event pulse |
| ev_xoff_char | input | 1 | Flow-stop or special character event pulse |
| ev_flow_change | input | 1 | Flow-control pin change event pulse |
| stat_rd | input | 1 | Status read cycle, high for the whole read |
| data_rd | input | 1 | Receive data read strobe |
| line_stat_rd | input | 1 | Line status read strobe |
| modem_stat_rd | input | 1 | Modem status read strobe |
| tx_hold_wr | input | 1 | Transmit holding register write strobe |
| irq | output | 1 | Interrupt request |
| int_status | output | 8 | Identification byte |

## Verification
Level inputs (`rx_data_avail`, `ien`, `fifo_en`) reach `irq` and the status byte in the same cycle, through combinational logic only. Event pulses and clear strobes act at the next rising edge, so their effect is visible from the following cycle. The rising edge of transmit-empty and the end-of-read clears also need one edge. The bench changes inputs at the falling edge and samples 1 ns later, before the next rising edge. Its reference model advances only at the rising edge, so every expected value is due in exactly the cycle in which it is compared. A read freeze starts from the second cycle of `stat_rd`, and the bench models this by keeping the value it captured in the read's first cycle.

// File: rtl/uart_irq_pkg.sv
`timescale 1ns/1ps
package uart_irq_pkg;
  localparam int NUM_SRC = 7;
  localparam int IDX_W   = $clog2(NUM_SRC);
  localparam int EN_W    = 6;
  localparam int CODE_W  = 6;
  localparam int STAT_W  = CODE_W + 2;

  // source indices, lower index = higher priority
  localparam int SRC_LINE  = 0;
  localparam int SRC_RXRDY = 1;
  localparam int SRC_RXTMO = 2;
  localparam int SRC_THRE  = 3;
  localparam int SRC_MODEM = 4;
  localparam int SRC_XOFF  = 5;
  localparam int SRC_FLOW  = 6;

  // enable bit positions
  localparam int EN_RX    = 0;
  localparam int EN_THR   = 1;
  localparam int EN_LINE  = 2;
  localparam int EN_MODEM = 3;
  localparam int EN_XOFF  = 4;
  localparam int EN_FLOW  = 5;

  localparam logic [CODE_W-1:0] CODE_NONE  = 6'b000001;
  localparam logic [CODE_W-1:0] CODE_LINE  = 6'b000110;
  localparam logic [CODE_W-1:0] CODE_RXRDY = 6'b000100;
  localparam logic [CODE_W-1:0] CODE_RXTMO = 6'b001100;
  localparam logic [CODE_W-1:0] CODE_THRE  = 6'b000010;
  localparam logic [CODE_W-1:0] CODE_MODEM = 6'b000000;
  localparam logic [CODE_W-1:0] CODE_XOFF  = 6'b010000;
  localparam logic [CODE_W-1:0] CODE_FLOW  = 6'b100000;

  function automatic logic [CODE_W-1:0] src_code(input logic [IDX_W-1:0] idx);
    case (idx)
      IDX_W'(SRC_LINE):  return CODE_LINE;
      IDX_W'(SRC_RXRDY): return CODE_RXRDY;
      IDX_W'(SRC_RXTMO): return CODE_RXTMO;
      IDX_W'(SRC_THRE):  return CODE_THRE;
      IDX_W'(SRC_MODEM): return CODE_MODEM;
      IDX_W'(SRC_XOFF):  return CODE_XOFF;
      IDX_W'(SRC_FLOW):  return CODE_FLOW;
      default:           return CODE_NONE;
    endcase
  endfunction

  function automatic int src_en_bit(input int src);
    case (src)
      SRC_LINE:               return EN_LINE;
      SRC_RXRDY, SRC_RXTMO:   return EN_RX;
      SRC_THRE:               return EN_THR;
      SRC_MODEM:              return EN_MODEM;
      SRC_XOFF:               return EN_XOFF;
      default:                return EN_FLOW;
    endcase
  endfunction
endpackage

// File: rtl/uart_irq_latch.sv
`timescale 1ns/1ps
module uart_irq_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  // a new event in the clearing cycle survives
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_o <= 1'b0;
    else        q_o <= set_i | (q_o & ~clr_i);
  end
endmodule

// File: rtl/uart_irq_prio.sv
`timescale 1ns/1ps
module uart_irq_prio #(
  parameter int N = 7,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req_i,
  output logic          found_o,
  output logic [IW-1:0] idx_o
);
  // scan from lowest priority upward so the smallest index wins
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        found_o = 1'b1;
        idx_o   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/uart_irq_rdhold.sv
`timescale 1ns/1ps
module uart_irq_rdhold #(
  parameter int W = 6,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         rd_i,
  input  logic [W-1:0] live_i,
  output logic [W-1:0] shown_o,
  output logic [W-1:0] snap_o,
  output logic         rd_end_o
);
  logic         rd_q;
  logic [W-1:0] snap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q   <= 1'b0;
      snap_q <= RST_VAL;
    end else begin
      rd_q <= rd_i;
      if (rd_i && !rd_q) snap_q <= live_i;
    end
  end

  assign shown_o  = (rd_i && rd_q) ? snap_q : live_i;
  assign snap_o   = snap_q;
  assign rd_end_o = rd_q && !rd_i;
endmodule

// File: rtl/uart_irq_ident.sv
`timescale 1ns/1ps
module uart_irq_ident
  import uart_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fifo_en,
  input  logic [EN_W-1:0]   ien,
  input  logic              ev_line_err,
  input  logic              rx_data_avail,
  input  logic              ev_rx_timeout,
  input  logic              tx_hold_empty,
  input  logic              ev_modem_delta,
  input  logic              ev_xoff_char,
  input  logic              ev_flow_change,
  input  logic              stat_rd,
  input  logic              data_rd,
  input  logic              line_stat_rd,
  input  logic              modem_stat_rd,
  input  logic              tx_hold_wr,
  output logic              irq,
  output logic [STAT_W-1:0] int_status
);
  logic [NUM_SRC-1:0] raw;
  logic [NUM_SRC-1:0] pend;
  logic               found;
  logic [IDX_W-1:0]   top_idx;
  logic [CODE_W-1:0]  live_code;
  logic [CODE_W-1:0]  shown_code;
  logic [CODE_W-1:0]  snap_code;
  logic               rd_end;
  logic               thr_req_q;
  logic               thr_rise;

  // transmit-empty is an edge on the enabled level
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) thr_req_q <= 1'b0;
    else        thr_req_q <= tx_hold_empty & ien[EN_THR];
  end
  assign thr_rise = tx_hold_empty & ien[EN_THR] & ~thr_req_q;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    if (i == SRC_RXRDY) begin : g_level
      assign raw[i] = rx_data_avail;
    end else begin : g_event
      logic s_set, s_clr;
      always_comb begin
        case (i)
          SRC_LINE:  begin s_set = ev_line_err;    s_clr = line_stat_rd;  end
          SRC_RXTMO: begin s_set = ev_rx_timeout;  s_clr = data_rd;       end
          SRC_THRE:  begin s_set = thr_rise;
                           s_clr = tx_hold_wr | (rd_end && snap_code == CODE_THRE); end
          SRC_MODEM: begin s_set = ev_modem_delta; s_clr = modem_stat_rd; end
          SRC_XOFF:  begin s_set = ev_xoff_char;
                           s_clr = rd_end && snap_code == CODE_XOFF; end
          default:   begin s_set = ev_flow_change; s_clr = modem_stat_rd; end
        endcase
      end
      uart_irq_latch u_lat (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (s_set),
        .clr_i (s_clr),
        .q_o   (raw[i])
      );
    end
    assign pend[i] = raw[i] & ien[src_en_bit(i)];
  end

  uart_irq_prio #(.N(NUM_SRC)) u_prio (
    .req_i   (pend),
    .found_o (found),
    .idx_o   (top_idx)
  );

  assign live_code = found ? src_code(top_idx) : CODE_NONE;

  uart_irq_rdhold #(.W(CODE_W), .RST_VAL(CODE_NONE)) u_hold (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_i     (stat_rd),
    .live_i   (live_code),
    .shown_o  (shown_code),
    .snap_o   (snap_code),
    .rd_end_o (rd_end)
  );

  assign irq        = found;
  assign int_status = {{2{fifo_en}}, shown_code};
endmodule

// File: rtl/uart_irq_ident_chk.sv
`timescale 1ns/1ps
module uart_irq_ident_chk
  import uart_irq_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              fifo_en,
  input logic [EN_W-1:0]   ien,
  input logic              ev_line_err,
  input logic              rx_data_avail,
  input logic              ev_rx_timeout,
  input logic              tx_hold_empty,
  input logic              ev_modem_delta,
  input logic              ev_xoff_char,
  input logic              ev_flow_change,
  input logic              stat_rd,
  input logic              data_rd,
  input logic              line_stat_rd,
  input logic              modem_stat_rd,
  input logic              tx_hold_wr,
  input logic              irq,
  input logic [STAT_W-1:0] int_status
);
  // R1
  idle_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq && !stat_rd) |-> int_status[CODE_W-1:0] == CODE_NONE);

  // R2
  pend_bit0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !stat_rd) |-> !int_status[0]);

  // R9
  read_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && $past(stat_rd)) |-> $stable(int_status[CODE_W-1:0]));

  // R3
  line_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_line_err && ien[EN_LINE] && !stat_rd)
      |=> (int_status[CODE_W-1:0] == CODE_LINE || !ien[EN_LINE]));

  // R6
  flow_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_flow_change && ien[EN_FLOW] && !modem_stat_rd) |=> (irq || !ien[EN_FLOW]));

  // R12
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_modem_delta && modem_stat_rd && ien[EN_MODEM]) |=> (irq || !ien[EN_MODEM]));
endmodule

bind uart_irq_ident uart_irq_ident_chk u_chk (.*);

// File: tb/uart_irq_ident_test.sv
`timescale 1ns/1ps
module uart_irq_ident_test;
  typedef struct packed {
    logic       fifo_en;
    logic [5:0] ien;
    logic       ev_line, rx, ev_to, tx, ev_ms, ev_xo, ev_fl;
    logic       rd, drd, lrd, mrd, twr;
  } stim_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  stim_t      s, d;
  logic       irq;
  logic [7:0] int_status;
  int         tests = 0;
  int         fails = 0;

  // reference state
  logic       m_ls, m_to, m_thr, m_ms, m_xo, m_fl, m_txp, m_rdq;
  logic [5:0] m_snap;

  always #4 clk = ~clk;

  uart_irq_ident uut (
    .clk(clk), .rst_n(rst_n), .fifo_en(d.fifo_en), .ien(d.ien),
    .ev_line_err(d.ev_line), .rx_data_avail(d.rx), .ev_rx_timeout(d.ev_to),
    .tx_hold_empty(d.tx), .ev_modem_delta(d.ev_ms), .ev_xoff_char(d.ev_xo),
    .ev_flow_change(d.ev_fl), .stat_rd(d.rd), .data_rd(d.drd),
    .line_stat_rd(d.lrd), .modem_stat_rd(d.mrd), .tx_hold_wr(d.twr),
    .irq(irq), .int_status(int_status)
  );

  function automatic logic [5:0] model_live();
    if (m_ls && d.ien[2])       return 6'h06;
    else if (d.rx && d.ien[0])  return 6'h04;
    else if (m_to && d.ien[0])  return 6'h0C;
    else if (m_thr && d.ien[1]) return 6'h02;
    else if (m_ms && d.ien[3])  return 6'h00;
    else if (m_xo && d.ien[4])  return 6'h10;
    else if (m_fl && d.ien[5])  return 6'h20;
    return 6'h01;
  endfunction

  function automatic string code_req(input logic [5:0] c, input logic held);
    if (held) return "R9";
    case (c)
      6'h01:        return "R1";
      6'h06:        return "R3";
      6'h04, 6'h0C: return "R4";
      6'h02, 6'h00: return "R5";
      default:      return "R6";
    endcase
  endfunction

  task automatic check(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_step(input logic [5:0] lv);
    logic rd_end, rise;
    rd_end = !d.rd && m_rdq;
    rise   = d.tx && d.ien[1] && !m_txp;
    m_ls   = d.ev_line | (m_ls & !d.lrd);
    m_to   = d.ev_to   | (m_to & !d.drd);
    m_thr  = rise      | (m_thr & !(d.twr || (rd_end && m_snap == 6'h02)));
    m_ms   = d.ev_ms   | (m_ms & !d.mrd);
    m_xo   = d.ev_xo   | (m_xo & !(rd_end && m_snap == 6'h10));
    m_fl   = d.ev_fl   | (m_fl & !d.mrd);
    if (d.rd && !m_rdq) m_snap = lv;
    m_rdq  = d.rd;
    m_txp  = d.tx && d.ien[1];
  endtask

  // apply staged inputs at the falling edge, compare 1 ns later, advance model at the rising edge
  task automatic tick(input string tag, input int exp);
    logic [5:0] lv, ex;
    logic held;
    @(negedge clk);
    d = s;
    #1;
    lv   = model_live();
    held = d.rd && m_rdq;
    ex   = held ? m_snap : lv;
    check(int_status[5:0] == ex, code_req(ex, held), {2'b0, int_status[5:0]}, {2'b0, ex});
    check(irq == (lv != 6'h01), "R2", {7'b0, irq}, {7'b0, lv != 6'h01});
    check(int_status[7:6] == {2{d.fifo_en}}, "R8", {6'b0, int_status[7:6]}, {6'b0, {2{d.fifo_en}}});
    if (exp >= 0)
      check(int_status[5:0] == exp[5:0], tag, {2'b0, int_status[5:0]}, exp[7:0]);
    @(posedge clk);
    model_step(lv);
  endtask

  initial begin
    #800000;
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4051));
    s = '0; d = '0;
    {m_ls, m_to, m_thr, m_ms, m_xo, m_fl, m_txp, m_rdq} = '0;
    m_snap = 6'h01;
    repeat (2) @(negedge clk);
    #1;
    check(int_status[5:0] == 6'h01 && !irq, "R1", int_status, 8'h01);
    @(negedge clk);
    rst_n = 1'b1;
    s.ien = 6'h3F;
    tick("R1", 6'h01);

    // several sources at once: line first, then modem, then flow-stop
    s.ev_line = 1; s.ev_ms = 1; s.ev_xo = 1; s.ev_fl = 1;
    tick("R1", 6'h01);
    s.ev_line = 0; s.ev_ms = 0; s.ev_xo = 0; s.ev_fl = 0;
    tick("R3", 6'h06);
    s.lrd = 1; tick("R3", 6'h06);
    s.lrd = 0; tick("R7", 6'h00);
    s.mrd = 1; tick("R5", 6'h00);
    s.mrd = 0; tick("R6", 6'h10);
    s.rd = 1;  tick("R6", 6'h10);
    tick("R9", 6'h10);
    s.rd = 0;  tick("R6", 6'h10);
    tick("R11", 6'h01);

    // receive level versus timeout
    s.rx = 1; s.ev_to = 1; tick("R4", 6'h04);
    s.ev_to = 0; tick("R4", 6'h04);
    s.rx = 0; tick("R4", 6'h0C);
    s.drd = 1; tick("R12", 6'h0C);
    s.drd = 0; tick("R12", 6'h01);

    // transmit empty: edge set, cleared by write, then by read end
    s.tx = 1; tick("R10", 6'h01);
    tick("R5", 6'h02);
    s.twr = 1; tick("R10", 6'h02);
    s.twr = 0; tick("R10", 6'h01);
    tick("R10", 6'h01);
    s.tx = 0; tick("R10", 6'h01);
    s.tx = 1; tick("R10", 6'h01);
    tick("R10", 6'h02);
    s.rd = 1; tick("R10", 6'h02);
    s.rd = 0; tick("R10", 6'h02);
    tick("R10", 6'h01);
    s.tx = 0; tick("R10", 6'h01);

    // masked source stays hidden until enabled
    s.ien[3] = 0; s.ev_ms = 1; tick("R7", 6'h01);
    s.ev_ms = 0; tick("R7", 6'h01);
    check(irq == 1'b0, "R7", {7'b0, irq}, 8'h00);
    s.ien[3] = 1; tick("R7", 6'h00);
    s.mrd = 1; tick("R12", 6'h00);
    s.mrd = 0; tick("R12", 6'h01);

    // event in the same cycle as its clear wins
    s.ev_line = 1; s.lrd = 1; tick("R12", 6'h01);
    s.ev_line = 0; s.lrd = 0; tick("R12", 6'h06);
    s.lrd = 1; tick("R12", 6'h06);
    s.lrd = 0; tick("R12", 6'h01);

    // arrival during a read stays frozen out; flow-pin lowest
    s.fifo_en = 1; s.rd = 1; tick("R8", 6'h01);
    s.ev_line = 1; s.ev_fl = 1; tick("R9", 6'h01);
    s.ev_line = 0; s.ev_fl = 0; tick("R9", 6'h01);
    s.rd = 0; tick("R3", 6'h06);
    s.lrd = 1; tick("R3", 6'h06);
    s.lrd = 0; tick("R6", 6'h20);
    s.mrd = 1; tick("R6", 6'h20);
    s.mrd = 0; tick("R1", 6'h01);

    // constrained random
    for (int n = 0; n < 4000; n++) begin
      s.ev_line = ($urandom % 10) == 0;
      s.ev_to   = ($urandom % 10) == 0;
      s.ev_ms   = ($urandom % 10) == 0;
      s.ev_xo   = ($urandom % 10) == 0;
      s.ev_fl   = ($urandom % 10) == 0;
      s.drd     = ($urandom % 6) == 0;
      s.lrd     = ($urandom % 6) == 0;
      s.mrd     = ($urandom % 6) == 0;
      s.twr     = ($urandom % 8) == 0;
      if (($urandom % 12) == 0) s.rx = ~s.rx;
      if (($urandom % 8) == 0)  s.tx = ~s.tx;
      if (($urandom % 4) == 0)  s.rd = ~s.rd;
      if (($urandom % 40) == 0) s.ien = 6'($urandom);
      if (($urandom % 64) == 0) s.fifo_en = ~s.fifo_en;
      tick("rand", -1);
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule